// File: doc/BRIEF.md
# Event-Capable GPIO Port Controller

An eight-pin general-purpose I/O port with a small register bus. Software sets the output levels and reads back the real pin levels. Each pin has its own drive setup and its own event detector. A captured event sets a status bit. When that event is enabled, it raises either an interrupt-request line or a system-management-interrupt line, depending on the pin's routing.

The runtime registers cover all eight pins at once, and bit n of each one belongs to pin n. Per-pin setup is reached through a pin-select register: the configuration and routing addresses always show the registers of the selected pin. A lock bit freezes one pin's setup until the next reset.

Register addresses on the 3-bit bus: 0 output data, 1 input data, 2 event enable, 3 event status, 4 pin select, 5 pin configuration, 6 pin routing. Address 7 reads 0. Pin configuration bits are: bit0 output enable, bit1 push-pull (1) or open-drain (0), bit2 level mode (1) or edge mode (0), bit3 polarity (1 = high/rising, 0 = low/falling), bit7 lock. Other bits read 0. Pin routing bits [1:0] are: 00 none, 01 interrupt, 10 SMI, 11 none.

Top module: `gpio_evt_port`

## Requirements
- R1: After reset, every register reads 0, pin_oe is 0, and irq and smi are 0.
- R2: The input-data register returns pin_in as sampled through two flops, so it is readable on the cycle after the second rising clock edge.
- R3: pin_out equals the output-data register. A push-pull pin with output enable set drives always. An open-drain pin with output enable set drives only while its data bit is 0. A pin with output enable clear never drives.
- R4: In edge mode, a pin's status bit sets on the polarity-selected transition of its synchronized input, and only on that transition.
- R5: In level mode, the status bit sets while the synchronized input equals the polarity bit. Writing 1 to clear it has no effect while that level persists, because setting wins over clearing.
- R6: A status bit stays set until software writes 1 to it at address 3. Writing 0 leaves it unchanged.
- R7: irq is the OR over all pins of status, enable and route code 01. smi is the same OR for route code 10. Codes 00 and 11 drive neither line.
- R8: Pin select keeps only its low 3 bits. Addresses 5 and 6 read and write the selected pin's registers.
- R9: Once a pin's lock bit is set, writes to that pin's configuration and routing are ignored until reset. Other pins are not affected.
- R10: Writes to the input-data address do not change what it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| irq | output | 1 | Interrupt request |
| smi | output | 1 | System-management interrupt |

## Verification
A fault in the synchronizer or the edge history shows up in the status register three clock edges after a pin change. A wrong edge or level decision appears as a status bit that is missing or extra on that same cycle. Errors in the routing or enable state show on irq or smi immediately after the register write, because both lines are combinational from stored state. A corrupted lock or select register shows when a configuration write reads back the wrong value.

// File: rtl/gpio_evt_port.sv
module gpio_evt_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe,
  output logic       irq,
  output logic       smi
);
  localparam int PINS = 8;
  localparam int SW = $clog2(PINS);
  localparam logic [2:0] A_DOUT = 3'd0, A_DIN = 3'd1, A_EN = 3'd2, A_ST = 3'd3,
                         A_SEL = 3'd4, A_CFG = 3'd5, A_RTE = 3'd6;

  logic [PINS-1:0] dout_r, en_r, st_r, s1, s2, s3;
  logic [PINS-1:0] oe_r, pp_r, lvl_r, pol_r, lock_r;
  logic [PINS-1:0][1:0] rt_r;
  logic [SW-1:0] sel_r;
  logic [PINS-1:0] ev, to_irq, to_smi, clr;

  wire wr_cfg = bus_we && bus_addr == A_CFG && !lock_r[sel_r];
  wire wr_rte = bus_we && bus_addr == A_RTE && !lock_r[sel_r];
  assign clr = (bus_we && bus_addr == A_ST) ? bus_wdata : '0;

  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      if (lvl_r[i]) ev[i] = (s2[i] == pol_r[i]);
      else          ev[i] = pol_r[i] ? (s2[i] & ~s3[i]) : (~s2[i] & s3[i]);
      to_irq[i] = (rt_r[i] == 2'b01);
      to_smi[i] = (rt_r[i] == 2'b10);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s1, s2, s3} <= '0;
      {dout_r, en_r, st_r} <= '0;
      {oe_r, pp_r, lvl_r, pol_r, lock_r} <= '0;
      rt_r  <= '0;
      sel_r <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
      st_r <= (st_r & ~clr) | ev;
      if (bus_we && bus_addr == A_DOUT) dout_r <= bus_wdata;
      if (bus_we && bus_addr == A_EN)   en_r   <= bus_wdata;
      if (bus_we && bus_addr == A_SEL)  sel_r  <= bus_wdata[SW-1:0];
      if (wr_cfg) begin
        oe_r[sel_r]   <= bus_wdata[0];
        pp_r[sel_r]   <= bus_wdata[1];
        lvl_r[sel_r]  <= bus_wdata[2];
        pol_r[sel_r]  <= bus_wdata[3];
        lock_r[sel_r] <= bus_wdata[7];
      end
      if (wr_rte) rt_r[sel_r] <= bus_wdata[1:0];
    end
  end

  assign pin_out = dout_r;
  assign pin_oe  = oe_r & (pp_r | ~dout_r);
  assign irq = |(st_r & en_r & to_irq);
  assign smi = |(st_r & en_r & to_smi);

  always_comb begin
    case (bus_addr)
      A_DOUT:  bus_rdata = dout_r;
      A_DIN:   bus_rdata = s2;
      A_EN:    bus_rdata = en_r;
      A_ST:    bus_rdata = st_r;
      A_SEL:   bus_rdata = {{(8-SW){1'b0}}, sel_r};
      A_CFG:   bus_rdata = {lock_r[sel_r], 3'b000, pol_r[sel_r], lvl_r[sel_r],
                            pp_r[sel_r], oe_r[sel_r]};
      A_RTE:   bus_rdata = {6'b0, rt_r[sel_r]};
      default: bus_rdata = 8'h00;
    endcase
  end

  // R6
  st_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_ST) |=> ((st_r & $past(st_r)) == $past(st_r)));

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CFG && lock_r[sel_r]) |=>
      (oe_r == $past(oe_r) && lock_r == $past(lock_r) && pol_r == $past(pol_r)));

  // R3
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & pin_out & ~pp_r) == 8'h00));

  // R7
  notify_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || smi) |-> (|(st_r & en_r)));
endmodule

// File: tb/gpio_evt_port_test.sv
module gpio_evt_port_test;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wd = 8'h00, pin = 8'h00;
  wire [7:0] rd, po, poe;
  wire irq, smi;
  int checks = 0, errors = 0, cyc = 0;

  gpio_evt_port uut (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wd),
    .bus_rdata(rd), .pin_in(pin), .pin_out(po), .pin_oe(poe), .irq(irq), .smi(smi)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wd = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rd;
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rdr(3'(a), v);
      chk($sformatf("R1 reg %0d", a), v, 0);
    end
    chk("R1 pin_oe", poe, 0);
    chk("R1 irq", irq, 0);
    chk("R1 smi", smi, 0);

    // R10 input data read-only
    wr(3'd1, 8'hFF);
    rdr(3'd1, v);
    chk("R10 din after write", v, 0);

    // R2 input sampling sweep
    for (int d = 0; d < 256; d++) begin
      @(negedge clk); pin = 8'(d);
      repeat (2) @(posedge clk);
      rdr(3'd1, v);
      chk("R2 din", v, d);
    end

    // R3 drive: even pins push-pull, odd pins open-drain, all enabled
    for (int n = 0; n < 8; n++) begin
      wr(3'd4, 8'(n));
      wr(3'd5, (n % 2 == 0) ? 8'h03 : 8'h01);
    end
    for (int d = 0; d < 256; d++) begin
      wr(3'd0, 8'(d));
      chk("R3 pin_out", po, d);
      chk("R3 pin_oe", poe, 8'h55 | (~8'(d) & 8'hAA));
    end

    // R8 select and indexed access
    wr(3'd4, 8'hFF);
    rdr(3'd4, v); chk("R8 sel masked", v, 7);
    rdr(3'd5, v); chk("R8 cfg pin7", v, 8'h01);
    wr(3'd4, 8'h0E);
    rdr(3'd4, v); chk("R8 sel 0x0E", v, 6);
    rdr(3'd5, v); chk("R8 cfg pin6", v, 8'h03);

    // R4 edge mode, every pin, both polarities, both transitions
    for (int n = 0; n < 8; n++) begin
      wr(3'd4, 8'(n));
      for (int p = 0; p < 2; p++) begin
        wr(3'd5, 8'(p << 3));
        for (int r = 0; r < 2; r++) begin
          @(negedge clk); pin[n] = (r == 0);
          repeat (4) @(negedge clk);
          wr(3'd3, 8'hFF);
          rdr(3'd3, v); chk("R4 cleared", v[n], 0);
          @(negedge clk); pin[n] = (r == 1);
          repeat (3) @(posedge clk);
          rdr(3'd3, v);
          chk($sformatf("R4 pin%0d pol%0d rise%0d", n, p, r), v[n], (p == r) ? 1 : 0);
        end
      end
    end

    // R5 / R6 level mode and write-1-to-clear
    for (int n = 0; n < 8; n++) begin
      wr(3'd4, 8'(n));
      for (int p = 0; p < 2; p++) begin
        wr(3'd5, 8'h04 | 8'(p << 3));
        @(negedge clk); pin[n] = p[0];
        repeat (4) @(negedge clk);
        rdr(3'd3, v); chk("R5 level sets", v[n], 1);
        wr(3'd3, 8'(1 << n));
        rdr(3'd3, v); chk("R5 clear while active", v[n], 1);
        @(negedge clk); pin[n] = ~p[0];
        repeat (4) @(negedge clk);
        rdr(3'd3, v); chk("R6 stays set", v[n], 1);
        wr(3'd3, 8'h00);
        rdr(3'd3, v); chk("R6 write0 no effect", v[n], 1);
        wr(3'd3, 8'(1 << n));
        rdr(3'd3, v); chk("R6 write1 clears", v[n], 0);
      end
      wr(3'd5, 8'h00);
    end
    wr(3'd3, 8'hFF);

    // R7 routing
    for (int n = 0; n < 8; n++) begin
      wr(3'd4, 8'(n));
      wr(3'd5, 8'h0C);
      @(negedge clk); pin[n] = 1'b1;
      repeat (4) @(negedge clk);
      for (int r = 0; r < 4; r++) begin
        wr(3'd6, 8'(r));
        wr(3'd2, 8'(1 << n));
        chk($sformatf("R7 irq pin%0d route%0d", n, r), irq, (r == 1) ? 1 : 0);
        chk($sformatf("R7 smi pin%0d route%0d", n, r), smi, (r == 2) ? 1 : 0);
        wr(3'd2, 8'(~(1 << n)));
        chk("R7 irq disabled", irq, 0);
        chk("R7 smi disabled", smi, 0);
      end
      wr(3'd2, 8'h00);
      wr(3'd6, 8'h00);
      wr(3'd5, 8'h00);
      @(negedge clk); pin[n] = 1'b0;
      repeat (4) @(negedge clk);
      wr(3'd3, 8'hFF);
    end

    // R9 lock
    wr(3'd0, 8'h00);
    wr(3'd4, 8'd2);
    wr(3'd5, 8'h81);
    wr(3'd5, 8'h0E);
    rdr(3'd5, v); chk("R9 cfg locked", v, 8'h81);
    wr(3'd6, 8'h01);
    rdr(3'd6, v); chk("R9 route locked", v, 0);
    chk("R9 locked pin drives", poe[2], 1);
    wr(3'd4, 8'd3);
    wr(3'd5, 8'h03);
    rdr(3'd5, v); chk("R9 other pin free", v, 8'h03);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule